// File: doc/BRIEF.md
# LCD Power-Up Sequencer

This block brings a register-indexed LCD controller from cold to ready after a system reset, with no software involved. It first holds the panel's reset pin low for a fixed time, releases it, and lets the panel settle. It then works through an internal table one entry at a time. Each entry is either a register write, made up of an index byte and a data byte, or a timed wait given in milliseconds.

Writes leave through a valid/ready handshake. The sequencer holds its place, index and data for as long as the receiver is not ready. Waits are timed by a millisecond timer. Its cycles-per-millisecond count comes from a clock-frequency parameter, and an override parameter can shrink that count so a bench runs quickly.

The default table does the following in order:
- writes the two oscillator values (0x36, then 0x01);
- steps the power-control register through 0x88, 0x80, 0x90 and 0xD0, with a 5 ms wait after each write;
- selects 16 bits per pixel with the value 0x05;
- writes display control 3 with 0x38, waits 40 ms, then writes it with 0x3C;
- sets memory access control to 0x08 as its final entry.

A ready flag rises once the last write has been accepted.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `panel_rst_n`, `wr_valid` and `seq_ready` are all low. A reset in the middle of a run restarts the sequence from the first table entry.
- R2: After reset is released, `panel_rst_n` stays low for exactly RST_MS*CPM+1 cycles, where CPM is the cycles-per-millisecond count. It then goes high and stays high until the next reset.
- R3: The first `wr_valid` appears exactly SETTLE_MS*CPM cycles after `panel_rst_n` rises. No write is offered while `panel_rst_n` is low.
- R4: Writes are offered in table order, with no entry skipped or repeated. Under the default table the accepted (index, data) pairs are, in order: (0x19,0x36), (0x1A,0x01), (0x1B,0x88), (0x1B,0x80), (0x1B,0x90), (0x1B,0xD0), (0x17,0x05), (0x28,0x38), (0x28,0x3C), (0x16,0x08).
- R5: A wait entry of N ms (N>0) places exactly N*CPM+2 cycles between the acceptance of the write before it and the acceptance of the write after it, when the receiver is always ready. Writes that follow one another directly are accepted in consecutive cycles.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_index` and `wr_data` hold their values into the next cycle.
- R7: `seq_ready` rises in the cycle after the final write is accepted. It then stays high, and no further write is offered, until the next reset.
- R8: CPM equals CLK_HZ/1000 when CYC_PER_MS_OVR is 0, and equals CYC_PER_MS_OVR otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| panel_rst_n | output | 1 | Active-low reset pin to the panel |
| wr_valid | output | 1 | A register write is offered |
| wr_ready | input | 1 | The receiver accepts the offered write |
| wr_index | output | 8 | Register index of the offered write |
| wr_data | output | 8 | Data byte of the offered write |
| seq_ready | output | 1 | The bring-up sequence has completed |

## Verification
The bench measures the exact cycle gaps around each timed wait, both the 5 ms steps and the 40 ms gap. A timer that is off by one millisecond, or that drops the extra handshake cycle, shows up as a wrong gap. It runs the whole sequence against a receiver that stalls often. A sequencer that advanced on `wr_valid` alone would skip entries, and one that changed its data during a stall would trip the hold check. It also resets the block in the middle of a wait and checks that the run starts again cleanly. Finally, a second instance without the override confirms that the millisecond count is derived from the clock frequency.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;
   localparam int IDX_W = 8;
   localparam int DAT_W = 8;
   localparam int ENT_W = 1 + IDX_W + DAT_W;

   localparam logic OP_WRITE = 1'b0;
   localparam logic OP_DELAY = 1'b1;

   // One table entry: for OP_WRITE arg is the data byte, for OP_DELAY it is milliseconds.
   typedef struct packed {
      logic             op;
      logic [IDX_W-1:0] idx;
      logic [DAT_W-1:0] arg;
   } seq_entry_t;

   localparam logic [IDX_W-1:0] RIX_OSC_A  = 8'h19;
   localparam logic [IDX_W-1:0] RIX_OSC_B  = 8'h1A;
   localparam logic [IDX_W-1:0] RIX_PWR    = 8'h1B;
   localparam logic [IDX_W-1:0] RIX_PIXFMT = 8'h17;
   localparam logic [IDX_W-1:0] RIX_DISP3  = 8'h28;
   localparam logic [IDX_W-1:0] RIX_MEMACC = 8'h16;

   localparam int DEF_N = 15;

   function automatic seq_entry_t ent_wr(input logic [IDX_W-1:0] i, input logic [DAT_W-1:0] d);
      seq_entry_t e;
      e.op  = OP_WRITE;
      e.idx = i;
      e.arg = d;
      return e;
   endfunction

   function automatic seq_entry_t ent_dly(input logic [DAT_W-1:0] ms);
      seq_entry_t e;
      e.op  = OP_DELAY;
      e.idx = '0;
      e.arg = ms;
      return e;
   endfunction

   function automatic logic [DEF_N*ENT_W-1:0] default_table();
      logic [DEF_N*ENT_W-1:0] t;
      t = '0;
      for (int k = 0; k < DEF_N; k++) begin
         seq_entry_t e;
         case (k)
            0:       e = ent_wr(RIX_OSC_A, 8'h36);
            1:       e = ent_wr(RIX_OSC_B, 8'h01);
            2:       e = ent_wr(RIX_PWR, 8'h88);
            3:       e = ent_dly(8'd5);
            4:       e = ent_wr(RIX_PWR, 8'h80);
            5:       e = ent_dly(8'd5);
            6:       e = ent_wr(RIX_PWR, 8'h90);
            7:       e = ent_dly(8'd5);
            8:       e = ent_wr(RIX_PWR, 8'hD0);
            9:       e = ent_dly(8'd5);
            10:      e = ent_wr(RIX_PIXFMT, 8'h05);
            11:      e = ent_wr(RIX_DISP3, 8'h38);
            12:      e = ent_dly(8'd40);
            13:      e = ent_wr(RIX_DISP3, 8'h3C);
            default: e = ent_wr(RIX_MEMACC, 8'h08);
         endcase
         t[k*ENT_W +: ENT_W] = e;
      end
      return t;
   endfunction
endpackage

// File: rtl/lcd_ms_timer.sv
`timescale 1ns/1ps
module lcd_ms_timer #(
   parameter int CYC_PER_MS = 200000,
   parameter int MS_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [MS_W-1:0] ms_i,
   output logic            busy_o,
   output logic            done_o
);
   localparam int CYC_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);

   if (CYC_PER_MS < 1) begin : g_bad_cpm
      $error("lcd_ms_timer: CYC_PER_MS must be at least 1");
   end
   if (MS_W < 1) begin : g_bad_msw
      $error("lcd_ms_timer: MS_W must be at least 1");
   end

   logic             busy_q;
   logic [CYC_W-1:0] cyc_q;
   logic [MS_W-1:0]  ms_q;

   assign busy_o = busy_q;
   assign done_o = busy_q && (cyc_q == '0) && (ms_q == MS_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cyc_q  <= '0;
         ms_q   <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cyc_q  <= CYC_LAST;
         ms_q   <= ms_i;
      end else if (busy_q) begin
         if (cyc_q == '0) begin
            if (ms_q == MS_W'(1)) begin
               busy_q <= 1'b0;
            end else begin
               ms_q  <= ms_q - 1'b1;
               cyc_q <= CYC_LAST;
            end
         end else begin
            cyc_q <= cyc_q - 1'b1;
         end
      end
   end

   // R5: a wait is never started with a zero length
   a_r5_start_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (ms_i != '0));
   // R5: the remaining millisecond count never reaches zero while busy
   a_r5_ms_live: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (ms_q != '0));
   // R8: the cycle counter stays inside one millisecond
   a_r8_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cyc_q <= CYC_LAST));
endmodule

// File: rtl/lcd_seq_table.sv
`timescale 1ns/1ps
module lcd_seq_table
   import lcd_seq_pkg::*;
#(
   parameter int NUM_ENT = DEF_N,
   parameter int PTR_W   = 4,
   parameter logic [NUM_ENT*ENT_W-1:0] TABLE = '0
) (
   input  logic [PTR_W-1:0] ptr_i,
   output seq_entry_t       ent_o,
   output logic             last_o
);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_ENT - 1);

   if (NUM_ENT < 1) begin : g_bad_n
      $error("lcd_seq_table: NUM_ENT must be at least 1");
   end

   seq_entry_t ents [NUM_ENT];

   for (genvar g = 0; g < NUM_ENT; g++) begin : g_unpack
      assign ents[g] = seq_entry_t'(TABLE[g*ENT_W +: ENT_W]);
   end

   if ((2 ** PTR_W) == NUM_ENT) begin : g_full_range
      assign ent_o = ents[ptr_i];
   end else begin : g_guarded
      assign ent_o = (ptr_i <= LAST_PTR) ? ents[ptr_i] : '0;
   end

   assign last_o = (ptr_i == LAST_PTR);
endmodule

// File: rtl/lcd_seq_ctrl.sv
`timescale 1ns/1ps
module lcd_seq_ctrl
   import lcd_seq_pkg::*;
#(
   parameter int PTR_W     = 4,
   parameter int RST_MS    = 1,
   parameter int SETTLE_MS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_entry_t       ent_i,
   input  logic             last_i,
   input  logic             tmr_done_i,
   output logic             tmr_start_o,
   output logic [DAT_W-1:0] tmr_ms_o,
   output logic [PTR_W-1:0] ptr_o,
   output logic             panel_rst_n,
   output logic             wr_valid,
   input  logic             wr_ready,
   output logic [IDX_W-1:0] wr_index,
   output logic [DAT_W-1:0] wr_data,
   output logic             seq_ready
);
   if (RST_MS < 1 || RST_MS >= (2 ** DAT_W)) begin : g_bad_rst
      $error("lcd_seq_ctrl: RST_MS out of range");
   end
   if (SETTLE_MS < 1 || SETTLE_MS >= (2 ** DAT_W)) begin : g_bad_settle
      $error("lcd_seq_ctrl: SETTLE_MS out of range");
   end

   typedef enum logic [2:0] {
      ST_ARM, ST_HOLD, ST_SETTLE, ST_RUN, ST_WAIT, ST_DONE
   } seq_state_e;

   seq_state_e       state_q, state_d;
   logic [PTR_W-1:0] ptr_q, ptr_d;
   logic             advance;

   always_comb begin
      state_d     = state_q;
      ptr_d       = ptr_q;
      tmr_start_o = 1'b0;
      tmr_ms_o    = '0;
      advance     = 1'b0;
      unique case (state_q)
         ST_ARM: begin
            tmr_start_o = 1'b1;
            tmr_ms_o    = DAT_W'(RST_MS);
            state_d     = ST_HOLD;
         end
         ST_HOLD: begin
            if (tmr_done_i) begin
               tmr_start_o = 1'b1;
               tmr_ms_o    = DAT_W'(SETTLE_MS);
               state_d     = ST_SETTLE;
            end
         end
         ST_SETTLE: begin
            if (tmr_done_i) state_d = ST_RUN;
         end
         ST_RUN: begin
            if (ent_i.op == OP_WRITE) begin
               advance = wr_ready;
            end else if (ent_i.arg == '0) begin
               advance = 1'b1;
            end else begin
               tmr_start_o = 1'b1;
               tmr_ms_o    = ent_i.arg;
               state_d     = ST_WAIT;
            end
         end
         ST_WAIT: begin
            advance = tmr_done_i;
         end
         default: ;
      endcase
      if (advance) begin
         if (last_i) begin
            state_d = ST_DONE;
         end else begin
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_RUN;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_ARM;
         ptr_q   <= '0;
      end else begin
         state_q <= state_d;
         ptr_q   <= ptr_d;
      end
   end

   assign ptr_o       = ptr_q;
   assign panel_rst_n = (state_q != ST_ARM) && (state_q != ST_HOLD);
   assign wr_valid    = (state_q == ST_RUN) && (ent_i.op == OP_WRITE);
   assign wr_index    = ent_i.idx;
   assign wr_data     = ent_i.arg;
   assign seq_ready   = (state_q == ST_DONE);

   // R6: an offered write holds still while the receiver stalls
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_index) && $stable(wr_data)));
   // R7: completion is sticky
   a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ready |=> seq_ready);
   // R7: nothing is offered after completion
   a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ready |-> !wr_valid);
   // R2: the panel reset pin never falls again once released
   a_r2_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      panel_rst_n |=> panel_rst_n);
   // R3: no write while the panel is held in reset
   a_r3_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_rst_n |-> !wr_valid);
   // R4: the table pointer moves only forward by one
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q != $past(ptr_q)) |-> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/lcd_bringup_seq.sv
`timescale 1ns/1ps
module lcd_bringup_seq
   import lcd_seq_pkg::*;
#(
   parameter int CLK_HZ         = 200_000_000,
   parameter int CYC_PER_MS_OVR = 0,
   parameter int RST_MS         = 1,
   parameter int SETTLE_MS      = 5,
   parameter int NUM_ENT        = DEF_N,
   parameter logic [NUM_ENT*ENT_W-1:0] TABLE = default_table()
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             panel_rst_n,
   output logic             wr_valid,
   input  logic             wr_ready,
   output logic [IDX_W-1:0] wr_index,
   output logic [DAT_W-1:0] wr_data,
   output logic             seq_ready
);
   localparam int CYC_PER_MS = (CYC_PER_MS_OVR != 0) ? CYC_PER_MS_OVR : (CLK_HZ / 1000);
   localparam int PTR_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

   if (CYC_PER_MS < 1) begin : g_bad_clk
      $error("lcd_bringup_seq: clock too slow for a millisecond count");
   end

   seq_entry_t       ent;
   logic             last;
   logic [PTR_W-1:0] ptr;
   logic             tmr_start, tmr_done, tmr_busy;
   logic [DAT_W-1:0] tmr_ms;

   lcd_seq_table #(
      .NUM_ENT (NUM_ENT),
      .PTR_W   (PTR_W),
      .TABLE   (TABLE)
   ) u_table (
      .ptr_i  (ptr),
      .ent_o  (ent),
      .last_o (last)
   );

   lcd_ms_timer #(
      .CYC_PER_MS (CYC_PER_MS),
      .MS_W       (DAT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tmr_start),
      .ms_i    (tmr_ms),
      .busy_o  (tmr_busy),
      .done_o  (tmr_done)
   );

   lcd_seq_ctrl #(
      .PTR_W     (PTR_W),
      .RST_MS    (RST_MS),
      .SETTLE_MS (SETTLE_MS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ent_i       (ent),
      .last_i      (last),
      .tmr_done_i  (tmr_done),
      .tmr_start_o (tmr_start),
      .tmr_ms_o    (tmr_ms),
      .ptr_o       (ptr),
      .panel_rst_n (panel_rst_n),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .wr_index    (wr_index),
      .wr_data     (wr_data),
      .seq_ready   (seq_ready)
   );

   // R5: no write is offered while a timed wait runs
   a_r5_quiet_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_busy |-> !wr_valid);
endmodule

// File: tb/tb_lcd_bringup_seq.sv
`timescale 1ns/1ps
module tb_lcd_bringup_seq;
   localparam int CPM  = 4;
   localparam int N_WR = 10;
   localparam int CPM2 = 12;

   // {index, data, cycles since previous acceptance (first: since panel reset release)}
   localparam logic [39:0] EXP [N_WR] = '{
      {8'h19, 8'h36, 24'(5*CPM)},
      {8'h1A, 8'h01, 24'(1)},
      {8'h1B, 8'h88, 24'(1)},
      {8'h1B, 8'h80, 24'(5*CPM+2)},
      {8'h1B, 8'h90, 24'(5*CPM+2)},
      {8'h1B, 8'hD0, 24'(5*CPM+2)},
      {8'h17, 8'h05, 24'(5*CPM+2)},
      {8'h28, 8'h38, 24'(1)},
      {8'h28, 8'h3C, 24'(40*CPM+2)},
      {8'h16, 8'h08, 24'(1)}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_ready = 1'b1;
   logic panel_rst_n, wr_valid, seq_ready;
   logic [7:0] wr_index, wr_data;
   logic panel2_n, valid2, ready2;
   logic [7:0] idx2, dat2;

   always #2.5 clk = ~clk;

   lcd_bringup_seq #(.CYC_PER_MS_OVR(CPM)) dut (
      .clk(clk), .rst_n(rst_n), .panel_rst_n(panel_rst_n), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .wr_index(wr_index), .wr_data(wr_data), .seq_ready(seq_ready));

   lcd_bringup_seq #(.CLK_HZ(CPM2*1000)) dut_hz (
      .clk(clk), .rst_n(rst_n), .panel_rst_n(panel2_n), .wr_valid(valid2),
      .wr_ready(1'b1), .wr_index(idx2), .wr_data(dat2), .seq_ready(ready2));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0;
   int n_bad = 0;

   logic [7:0] got_idx [32];
   logic [7:0] got_dat [32];
   int got_cyc [32];
   int n_acc, rise_cyc, done_cyc, low_cnt, stall_bad, stall_seen, late_valid;
   int low2, rise2, first2;
   logic prev_prst, prev_rdy, prev_stall, prev_p2;
   logic [7:0] prev_idx, prev_dat;

   task automatic clear_mon();
      n_acc = 0; rise_cyc = -1; done_cyc = -1; low_cnt = 0; stall_bad = 0;
      stall_seen = 0; late_valid = 0; low2 = 0; rise2 = -1; first2 = -1;
      prev_prst = 1'b0; prev_rdy = 1'b0; prev_stall = 1'b0; prev_p2 = 1'b0;
      prev_idx = '0; prev_dat = '0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (!panel_rst_n) low_cnt++;
         if (panel_rst_n && !prev_prst) rise_cyc = cyc;
         if (wr_valid && wr_ready && n_acc < 32) begin
            got_idx[n_acc] = wr_index;
            got_dat[n_acc] = wr_data;
            got_cyc[n_acc] = cyc;
            n_acc++;
         end
         if (seq_ready && !prev_rdy) done_cyc = cyc;
         if (seq_ready && wr_valid) late_valid++;
         if (prev_stall && !(wr_valid && wr_index == prev_idx && wr_data == prev_dat)) stall_bad++;
         if (wr_valid && !wr_ready) stall_seen++;
         prev_stall = wr_valid && !wr_ready;
         prev_idx = wr_index;
         prev_dat = wr_data;
         prev_prst = panel_rst_n;
         prev_rdy = seq_ready;
         if (!panel2_n) low2++;
         if (panel2_n && !prev_p2) rise2 = cyc;
         if (valid2 && first2 < 0) first2 = cyc;
         prev_p2 = panel2_n;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0;
      clear_mon();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!panel_rst_n, "R1 panel reset low in reset", int'(panel_rst_n), 0);
      chk(!wr_valid && !seq_ready, "R1 valid/ready low in reset", int'({wr_valid, seq_ready}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!panel_rst_n && !wr_valid && !seq_ready, "R1 outputs low after release",
          int'({panel_rst_n, wr_valid, seq_ready}), 0);
   endtask

   task automatic check_order(input string req);
      chk(n_acc == N_WR, req, n_acc, N_WR);
      for (int k = 0; k < N_WR; k++) begin
         chk(got_idx[k] == EXP[k][39:32], req, int'(got_idx[k]), int'(EXP[k][39:32]));
         chk(got_dat[k] == EXP[k][31:24], req, int'(got_dat[k]), int'(EXP[k][31:24]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      clear_mon();
      // Test A: always-ready receiver, exact order and timing (R2 R3 R4 R5 R7)
      wr_ready = 1'b1;
      do_reset();
      for (int i = 0; i < 3000 && !seq_ready; i++) @(posedge clk);
      @(negedge clk);
      chk(low_cnt == CPM + 1, "R2 panel reset length", low_cnt, CPM + 1);
      chk(low2 == CPM2 + 1, "R8 length from CLK_HZ", low2, CPM2 + 1);
      chk(first2 - rise2 == 5*CPM2, "R8 settle from CLK_HZ", first2 - rise2, 5*CPM2);
      check_order("R4 write order");
      for (int k = 0; k < N_WR; k++) begin
         int gap;
         gap = (k == 0) ? got_cyc[0] - rise_cyc : got_cyc[k] - got_cyc[k-1];
         chk(gap == int'(EXP[k][23:0]), (k == 0) ? "R3 settle gap" : "R5 gap", gap, int'(EXP[k][23:0]));
      end
      chk(done_cyc == got_cyc[N_WR-1] + 1, "R7 ready timing", done_cyc, got_cyc[N_WR-1] + 1);
      repeat (30) @(posedge clk);
      @(negedge clk);
      chk(seq_ready == 1'b1, "R7 ready sticky", int'(seq_ready), 1);
      chk(late_valid == 0, "R7 no write after done", late_valid, 0);

      // Test B: reset in the middle of the 5 ms waits, then a stalling receiver (R1 R6)
      do_reset();
      repeat (40) @(posedge clk);
      do_reset();
      for (int i = 0; i < 5000 && !seq_ready; i++) begin
         @(posedge clk); #1 wr_ready = ((i % 3) == 2);
      end
      #1 wr_ready = 1'b1;
      @(negedge clk);
      chk(low_cnt == CPM + 1, "R1 restart panel reset length", low_cnt, CPM + 1);
      check_order("R6 order under stalls");
      chk(stall_seen > 0, "R6 stalls exercised", stall_seen, 1);
      chk(stall_bad == 0, "R6 hold during stall", stall_bad, 0);
      chk(seq_ready == 1'b1, "R7 done after stalls", int'(seq_ready), 1);

      summary();
      $finish;
   end
endmodule